// File: doc/BRIEF.md
# Unlockable Banked Input Port Interface

This block is the byte-wide register face of a 32-line digital input block. A host reaches it through a single access strobe that carries a 3-bit port number, a read/write flag and a write byte. Ports 0 to 3 return eight input lines each. Port 7 is the control port. It holds one write-mask bit per input port and, once the block has been unlocked, a two-bit bank number. Ports 4 to 6 are empty. The read byte is combinational from the current port number.

The block starts in a plain mode. It moves to a banked mode only when a fixed four-byte key is written to the control port as the first four accesses after reset. In the banked mode, bank 0 behaves like the plain mode. For banks 1 and 2, accesses to ports 0 to 3 are handed to neighbouring blocks through a forward strobe, and this block returns zero for them. A write to an unmasked input port in bank 0 does not drive anything. Each 1 it writes blanks the matching input, so that input reads 0 until a 0 is written to that bit or the block is reset.

Top module: `banked_input_port`

## Requirements
- R1: After reset the mask is 0000, the mode is plain (`enh_mode`=0), `bank_sel` is 00, port 7 reads 00h, and input ports read their live input lines.
- R2: Port p (0 to 3) read-data bit b equals `in_lines[8p+b]`. Ports 4 to 6 read 00h.
- R3: A write to port 7 loads bits 3:0 into the mask, where bit p masks port p. Port 7 reads the mask in bits 3:0 and 0 in bits 5:4. In plain mode bits 7:6 also read 0.
- R4: A write to a port whose mask bit is 1 is discarded and changes nothing that can be read.
- R5: In plain mode or bank 0, writing 1 to a bit of an unmasked input port makes that input read 0 whatever the line does. Writing 0 to that bit restores live reading.
- R6: Writing the bytes 07h, 0Dh, 06h and 12h to port 7, in that order, as the first four accesses after reset sets `enh_mode`=1 after the fourth write. After that `enh_mode` stays 1 until reset.
- R7: Any other access during the key sequence permanently aborts the unlock until the next reset. This covers a wrong byte, an access to another port, and any read.
- R8: Each key byte also updates the mask as an ordinary port 7 write, so a completed unlock leaves the mask at 0010.
- R9: In banked mode a port 7 write loads bits 7:6 into the bank (00 input, 01 event, 10 debounce). Port 7 bits 7:6 and `bank_sel` show the current bank.
- R10: A port 7 write with bits 7:6 = 11 leaves the bank unchanged but still loads the mask.
- R11: In banked mode with bank 01 or 10, an access to ports 0 to 3 raises `fwd_access`, reads 00h from this block, and leaves the blanking state untouched. `fwd_access` is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 3 | Port number |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `acc_port` |
| in_lines | input | 32 | Live input lines, line 8p+b on port p bit b |
| enh_mode | output | 1 | Banked mode active |
| bank_sel | output | 2 | Current bank |
| fwd_access | output | 1 | Access belongs to the bank 1/2 neighbour |

## Verification
The bench builds the block with its default parameters: four lanes of eight lines, with the control port at 7. This makes every lane and every mask bit reachable, along with the two reserved bits 5:4 and the full two-bit bank field. Each unlock scenario starts from its own reset, so the abort-by-wrong-byte, abort-by-other-port and abort-by-read paths are each reached. The check after the completed unlock confirms the mask that the key bytes leave behind.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  localparam int unsigned KEY_LEN = 4;
  localparam logic [1:0]  BANK_INPUT = 2'b00;
  localparam logic [1:0]  BANK_RSVD  = 2'b11;

  // Unlock key byte expected at position idx of the sequence.
  function automatic logic [7:0] unlock_key(input int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'h0D;
      2:       return 8'h06;
      default: return 8'h12;
    endcase
  endfunction

  // Whether the register view of input ports belongs to this block.
  function automatic logic local_view(input logic enh, input logic [1:0] bank);
    return !enh || (bank == BANK_INPUT);
  endfunction
endpackage

// File: rtl/ibp_unlock_seq.sv
module ibp_unlock_seq
  import ibp_pkg::*;
#(
  parameter int PORT_AW   = 3,
  parameter int CTRL_PORT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [PORT_AW-1:0] acc_port,
  input  logic [7:0]         acc_wdata,
  output logic               enh,
  output logic               abort_evt,
  output logic               done_evt
);
  localparam int STEP_W = $clog2(KEY_LEN);
  localparam logic [PORT_AW-1:0] CTRL_P = PORT_AW'(CTRL_PORT);
  localparam logic [STEP_W-1:0]  LAST_STEP = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic              aborted_q;
  logic              enh_q;
  logic              armed;
  logic              key_hit;

  assign armed     = acc_valid && !enh_q && !aborted_q;
  assign key_hit   = acc_write && (acc_port == CTRL_P) && (acc_wdata == unlock_key(int'(step_q)));
  assign abort_evt = armed && !key_hit;
  assign done_evt  = armed && key_hit && (step_q == LAST_STEP);
  assign enh       = enh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= '0;
      aborted_q <= 1'b0;
      enh_q     <= 1'b0;
    end else if (abort_evt) begin
      aborted_q <= 1'b1;
    end else if (done_evt) begin
      enh_q     <= 1'b1;
    end else if (armed) begin
      step_q    <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/ibp_ctrl_regs.sv
module ibp_ctrl_regs
  import ibp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             enh,
  input  logic [LANES-1:0] mask_in,
  input  logic [1:0]       bank_in,
  output logic [LANES-1:0] mask,
  output logic [1:0]       bank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      bank <= BANK_INPUT;
    end else if (ctrl_wr) begin
      mask <= mask_in;
      if (enh && (bank_in != BANK_RSVD)) bank <= bank_in;
    end
  end
endmodule

// File: rtl/ibp_blank_latches.sv
module ibp_blank_latches #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [LANE_W-1:0]       wdata,
  output logic [LANES*LANE_W-1:0] blank
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)          blank[i*LANE_W +: LANE_W] <= '0;
      else if (lane_wr[i]) blank[i*LANE_W +: LANE_W] <= wdata;
    end
  end
endmodule

// File: rtl/banked_input_port.sv
module banked_input_port
  import ibp_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int PORT_AW   = 3,
  parameter int CTRL_PORT = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [PORT_AW-1:0]      acc_port,
  input  logic [LANE_W-1:0]       acc_wdata,
  output logic [LANE_W-1:0]       rd_data,
  input  logic [LANES*LANE_W-1:0] in_lines,
  output logic                    enh_mode,
  output logic [1:0]              bank_sel,
  output logic                    fwd_access
);
  localparam logic [PORT_AW-1:0] CTRL_P  = PORT_AW'(CTRL_PORT);
  localparam logic [PORT_AW-1:0] LANES_P = PORT_AW'(LANES);

  logic                    enh;
  logic                    unlock_abort;
  logic                    unlock_done;
  logic [LANES-1:0]        mask;
  logic [1:0]              bank;
  logic [LANES*LANE_W-1:0] blank;
  logic [LANES-1:0]        lane_wr;
  logic                    ctrl_wr;
  logic                    own_view;
  logic                    lane_hit;

  assign ctrl_wr  = acc_valid && acc_write && (acc_port == CTRL_P);
  assign own_view = local_view(enh, bank);
  assign lane_hit = acc_port < LANES_P;

  for (genvar i = 0; i < LANES; i++) begin : g_wr
    assign lane_wr[i] = acc_valid && acc_write && (acc_port == PORT_AW'(i))
                        && !mask[i] && own_view;
  end

  ibp_unlock_seq #(.PORT_AW(PORT_AW), .CTRL_PORT(CTRL_PORT)) u_unlock (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata[7:0]), .enh(enh),
    .abort_evt(unlock_abort), .done_evt(unlock_done)
  );

  ibp_ctrl_regs #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .enh(enh),
    .mask_in(acc_wdata[LANES-1:0]), .bank_in(acc_wdata[LANE_W-1 -: 2]),
    .mask(mask), .bank(bank)
  );

  ibp_blank_latches #(.LANES(LANES), .LANE_W(LANE_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .wdata(acc_wdata), .blank(blank)
  );

  always_comb begin
    rd_data = '0;
    if (acc_port == CTRL_P) begin
      rd_data[LANES-1:0] = mask;
      if (enh) rd_data[LANE_W-1 -: 2] = bank;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (acc_port == PORT_AW'(i) && own_view)
          rd_data = in_lines[i*LANE_W +: LANE_W] & ~blank[i*LANE_W +: LANE_W];
      end
    end
  end

  assign enh_mode   = enh;
  assign bank_sel   = bank;
  assign fwd_access = acc_valid && lane_hit && !own_view;
endmodule

// File: rtl/ibp_checker.sv
module ibp_checker #(
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int PORT_AW   = 3,
  parameter int CTRL_PORT = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic                    acc_write,
  input logic [PORT_AW-1:0]      acc_port,
  input logic [LANE_W-1:0]       acc_wdata,
  input logic [LANE_W-1:0]       rd_data,
  input logic                    enh,
  input logic [1:0]              bank,
  input logic [LANES-1:0]        mask,
  input logic [LANES*LANE_W-1:0] blank,
  input logic                    fwd,
  input logic                    unlock_abort
);
  localparam logic [PORT_AW-1:0] CTRL_P  = PORT_AW'(CTRL_PORT);
  localparam logic [PORT_AW-1:0] LANES_P = PORT_AW'(LANES);

  logic masked_wr;
  always_comb begin
    masked_wr = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (acc_valid && acc_write && acc_port == PORT_AW'(i) && mask[i]) masked_wr = 1'b1;
  end

  AST_BANK_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    bank != 2'b11); // R10
  AST_PLAIN_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enh |-> bank == 2'b00); // R9
  AST_ENH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enh |=> enh); // R6
  AST_ENH_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh) |-> $past(acc_valid && acc_write && acc_port == CTRL_P && acc_wdata == 8'h12)); // R6
  AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_abort && !enh) |=> !enh); // R7
  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_port == CTRL_P |-> rd_data[LANE_W-3:LANES] == '0); // R3
  AST_MASKED_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    masked_wr |=> $stable(blank)); // R4
  AST_FWD_ONLY_BANKED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (enh && bank != 2'b00 && acc_port < LANES_P)); // R11
endmodule

bind banked_input_port ibp_checker #(
  .LANES(LANES), .LANE_W(LANE_W), .PORT_AW(PORT_AW), .CTRL_PORT(CTRL_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_port(acc_port), .acc_wdata(acc_wdata), .rd_data(rd_data), .enh(enh),
  .bank(bank), .mask(mask), .blank(blank), .fwd(fwd_access),
  .unlock_abort(unlock_abort)
);

// File: tb/tb_banked_input_port.sv
module tb_banked_input_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0;
  logic        acc_write = 0;
  logic [2:0]  acc_port = 0;
  logic [7:0]  acc_wdata = 0;
  logic [7:0]  rd_data;
  logic [31:0] in_lines = 0;
  logic        enh_mode;
  logic [1:0]  bank_sel;
  logic        fwd_access;

  int total = 0;
  int fails = 0;
  logic [7:0] rv;
  logic       last_fwd;

  always #2 clk = ~clk;

  banked_input_port dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .in_lines(in_lines), .enh_mode(enh_mode), .bank_sel(bank_sel),
    .fwd_access(fwd_access)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0; acc_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_port = p; acc_wdata = d;
    #1 last_fwd = fwd_access;
    @(posedge clk);
    #1 acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [2:0] p, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_port = p;
    #1 d = rd_data; last_fwd = fwd_access;
    @(posedge clk);
    #1 acc_valid = 0;
  endtask

  task automatic t_reset();
    in_lines = 32'hA5C3_0F81;
    apply_reset();
    check("R1 enh_mode", enh_mode, 0);
    check("R1 bank_sel", bank_sel, 0);
    rd(3'd7, rv); check("R1 port7", rv, 8'h00);
    rd(3'd0, rv); check("R1 port0 live", rv, 8'h81);
  endtask

  task automatic t_mapping();
    rd(3'd1, rv); check("R2 port1", rv, 8'h0F);
    rd(3'd2, rv); check("R2 port2", rv, 8'hC3);
    rd(3'd3, rv); check("R2 port3", rv, 8'hA5);
    rd(3'd5, rv); check("R2 port5 empty", rv, 8'h00);
    in_lines = 32'h0000_0400;
    rd(3'd1, rv); check("R2 bit2 of port1", rv, 8'h04);
  endtask

  task automatic t_blank();
    in_lines = 32'h0000_0F00;
    wr(3'd1, 8'h0F);
    rd(3'd1, rv); check("R5 blanked", rv, 8'h00);
    in_lines = 32'h0000_FF00;
    rd(3'd1, rv); check("R5 blanked ignores change", rv, 8'hF0);
    wr(3'd1, 8'h00);
    rd(3'd1, rv); check("R5 restored", rv, 8'hFF);
    check("R11 no fwd in plain mode", last_fwd, 0);
  endtask

  task automatic t_mask();
    in_lines = 32'h0000_FFFF;
    wr(3'd7, 8'hF6);
    rd(3'd7, rv); check("R3 mask readback plain", rv, 8'h06);
    wr(3'd1, 8'hFF);
    rd(3'd1, rv); check("R4 masked write dropped", rv, 8'hFF);
    wr(3'd0, 8'hFF);
    rd(3'd0, rv); check("R5 unmasked port blanks", rv, 8'h00);
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h00);
    rd(3'd0, rv); check("R3 mask cleared", rv, 8'hFF);
  endtask

  task automatic t_unlock_wrong();
    apply_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h05);
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R7 wrong byte aborts", enh_mode, 0);
    rd(3'd7, rv); check("R7 plain readback", rv, 8'h02);
  endtask

  task automatic t_unlock_other();
    apply_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); rd(3'd0, rv); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R7 other-port access aborts", enh_mode, 0);
    apply_reset();
    wr(3'd7, 8'h07); rd(3'd7, rv);
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R7 read aborts", enh_mode, 0);
  endtask

  task automatic t_unlock_ok();
    apply_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h06);
    check("R6 not yet unlocked", enh_mode, 0);
    wr(3'd7, 8'h12);
    check("R6 unlocked", enh_mode, 1);
    rd(3'd7, rv); check("R8 mask after key", rv, 8'h02);
  endtask

  task automatic t_banks();
    in_lines = 32'h0000_00AA;
    wr(3'd7, 8'h41);
    check("R9 bank_sel 1", bank_sel, 1);
    rd(3'd7, rv); check("R9 readback bank1", rv, 8'h41);
    rd(3'd0, rv);
    check("R11 fwd on bank1 read", last_fwd, 1);
    check("R11 read zero bank1", rv, 8'h00);
    wr(3'd0, 8'hFF);
    check("R11 fwd on bank1 write", last_fwd, 1);
    wr(3'd7, 8'hC3);
    rd(3'd7, rv); check("R10 invalid bank ignored, mask loaded", rv, 8'h43);
    wr(3'd7, 8'h80);
    check("R9 bank_sel 2", bank_sel, 2);
    rd(3'd6, rv); check("R11 no fwd port6", last_fwd, 0);
    wr(3'd7, 8'h00);
    rd(3'd0, rv);
    check("R11 blanking untouched", rv, 8'hAA);
    check("R11 no fwd bank0", last_fwd, 0);
    check("R6 stays enhanced", enh_mode, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_mapping();
    t_blank();
    t_mask();
    t_unlock_wrong();
    t_unlock_other();
    t_unlock_ok();
    t_banks();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule